// File: doc/BRIEF.md
# Multi-Channel Interval Timer Bank

This block holds three reloadable down-counters and one wide free-running up-counter behind a simple word-addressed register port. The two narrow channels count in 16 bits and the third in 32 bits. Each reloadable channel has four registers: load, live value, control and interrupt clear. Each channel drives one level interrupt that is raised when its count passes zero. The 40-bit up-counter never interrupts. It is read as a low word and a high word, and a coherent snapshot of its upper bits is taken when the low word is read.

Counting is paced by two single-cycle tick strobes, one slow and one fast, which the block receives from outside. Each reloadable channel picks one of the two with its clock-select bit. The wide counter always advances on the fast strobe. To set up a periodic interrupt every N ticks, software writes the mode, then writes N-1 to the load register, then sets the enable bit.

The register port is plain control, with no stream handshake. A write takes effect at the clock edge where `wr_en` is high. A read is registered: `rdata` shows the addressed register in the cycle after `rd_en` and holds that value until the next read.

Top module: `tmr_bank`

## Requirements
- R1: After reset every load, value and control register reads 0, all three interrupts are low, and the wide counter reads 0 and is disabled.
- R2: Channel register groups sit at byte offsets 0x00, 0x20 and 0x80, with load at +0x0, value at +0x4, control at +0x8 and clear at +0xC. Control keeps only bit 7 (enable), bit 6 (periodic) and bit 3 (clock select). The clear register reads 0. Read data appears in the cycle after `rd_en`.
- R3: Writing the load register while the channel is disabled also copies the value into the count.
- R4: An enabled channel decrements by one on each tick of its selected strobe, where clock select 1 means `tick_fast` and 0 means `tick_slow`. The strobe that is not selected has no effect.
- R5: In periodic mode, a tick at count 0 reloads the count from the load register and raises the channel interrupt, so a load of N-1 gives one interrupt every N ticks.
- R6: In non-periodic mode, a tick at count 0 wraps the count to all ones and raises the interrupt.
- R7: Channels at 0x00 and 0x20 are 16 bits wide and wrap to 0xFFFF. The channel at 0x80 is 32 bits wide and wraps to 0xFFFFFFFF.
- R8: A write of any data to a channel's clear register drops its interrupt.
- R9: Clearing the enable bit freezes the count and leaves a pending interrupt asserted.
- R10: The wide counter increments by one on each `tick_fast` while bit 8 of the register at 0x64 is set. It does not count while that bit is clear, and it affects no interrupt line.
- R11: Reading 0x60 returns the low 32 bits of the wide counter and captures its upper 8 bits. Reading 0x64 returns the captured bits in [7:0] and the enable in bit 8, even if the counter has advanced since the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address; bits [1:0] ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tick_slow | input | 1 | Slow count strobe |
| tick_fast | input | 1 | Fast count strobe |
| irq | output | 3 | Level interrupt for each reloadable channel |

## Verification
The hardest situation to reach from the ports is a channel passing zero while it runs on the strobe it did not start on, with ticks of the other strobe mixed in. The stimulus builds this with random load values, modes, clock selects and tick counts taken from a fixed seed. Ticks of the strobe that is not selected are interleaved with the counted ones, and each run ends on a frozen count that a reference function predicts. Directed cases cover the wrap to all ones at both widths, the enable bit being dropped while an interrupt is pending, and the wide counter advancing between a low-word read and the high-word read that follows it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_LOAD  = 0;
  localparam int REG_VALUE = 1;
  localparam int REG_CTRL  = 2;
  localparam int REG_CLEAR = 3;
  localparam int CB_EN   = 7;
  localparam int CB_PER  = 6;
  localparam int CB_CSEL = 3;
  localparam int FREE_EN_BIT = 8;
  localparam logic [7:0] FREE_LO_OFS = 8'h60;
  localparam logic [7:0] FREE_HI_OFS = 8'h64;

  typedef struct packed {
    logic en;
    logic per;
    logic csel;
  } ctrl_t;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W = 16,
  parameter logic [7:0] BASE = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  input  logic        tick_slow,
  input  logic        tick_fast,
  output logic [31:0] rd_word,
  output logic        irq
);
  logic [W-1:0] load_q, count_q;
  ctrl_t        ctrl_q;
  logic         pend_q;
  logic         grp;
  logic [1:0]   idx;
  logic         wr_ld, wr_ct, wr_clr, tick_sel, step, under;
  logic         unused_bits;

  assign grp      = (addr[7:4] == BASE[7:4]);
  assign idx      = addr[3:2];
  assign wr_ld    = wr_en && grp && (idx == 2'(REG_LOAD));
  assign wr_ct    = wr_en && grp && (idx == 2'(REG_CTRL));
  assign wr_clr   = wr_en && grp && (idx == 2'(REG_CLEAR));
  assign tick_sel = ctrl_q.csel ? tick_fast : tick_slow;
  assign step     = ctrl_q.en && tick_sel;
  assign under    = step && (count_q == '0);
  assign unused_bits = ^{addr[1:0], rd_en, wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q  <= '0;
      count_q <= '0;
      ctrl_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_ld) load_q <= wdata[W-1:0];
      if (wr_ct) ctrl_q <= '{en: wdata[CB_EN], per: wdata[CB_PER], csel: wdata[CB_CSEL]};
      if (step) begin
        if (under) count_q <= ctrl_q.per ? load_q : '1;
        else       count_q <= count_q - 1'b1;
      end else if (wr_ld && !ctrl_q.en) begin
        count_q <= wdata[W-1:0];
      end
      if (under)       pend_q <= 1'b1;
      else if (wr_clr) pend_q <= 1'b0;
    end
  end

  always_comb begin
    rd_word = '0;
    if (grp) begin
      case (idx)
        2'(REG_LOAD):  rd_word = 32'(load_q);
        2'(REG_VALUE): rd_word = 32'(count_q);
        2'(REG_CTRL):  begin
          rd_word[CB_EN]   = ctrl_q.en;
          rd_word[CB_PER]  = ctrl_q.per;
          rd_word[CB_CSEL] = ctrl_q.csel;
        end
        default:       rd_word = '0;
      endcase
    end
  end

  assign irq = pend_q;

  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(under));
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (under && ctrl_q.per && !wr_ld) |=> (count_q == $past(load_q)));
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (under && !ctrl_q.per) |=> (&count_q));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !under) |=> !pend_q);
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !wr_ld) |=> $stable(count_q));
  p_keep_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !wr_clr) |=> pend_q);
endmodule

// File: rtl/tmr_free.sv
module tmr_free
  import tmr_pkg::*;
#(
  parameter int W = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  input  logic        tick_fast,
  output logic [31:0] rd_word
);
  localparam int HW = W - 32;

  logic [W-1:0]  cnt_q;
  logic [HW-1:0] hold_q;
  logic          en_q;
  logic          sel_lo, sel_hi;
  logic          unused_bits;

  assign sel_lo = ({addr[7:2], 2'b00} == FREE_LO_OFS);
  assign sel_hi = ({addr[7:2], 2'b00} == FREE_HI_OFS);
  assign unused_bits = ^{addr[1:0], wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_en && sel_hi) en_q <= wdata[FREE_EN_BIT];
      if (en_q && tick_fast) cnt_q <= cnt_q + 1'b1;
      if (rd_en && sel_lo) hold_q <= cnt_q[W-1:32];
    end
  end

  always_comb begin
    rd_word = '0;
    if (sel_lo) rd_word = cnt_q[31:0];
    else if (sel_hi) begin
      rd_word[HW-1:0]      = hold_q;
      rd_word[FREE_EN_BIT] = en_q;
    end
  end

  p_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick_fast) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q || !tick_fast) |=> $stable(cnt_q));
  p_snap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_lo) |=> (hold_q == $past(cnt_q[W-1:32])));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int FREE_W   = 40,
  parameter int N_CH     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        tick_slow,
  input  logic        tick_fast,
  output logic [2:0]  irq
);
  logic [31:0] ch_rd [N_CH];
  logic [31:0] free_rd;
  logic [31:0] rd_mux;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam int CW = (i == N_CH - 1) ? WIDE_W : NARROW_W;
    localparam logic [7:0] CB = (i == 0) ? 8'h00 : (i == 1) ? 8'h20 : 8'h80;
    tmr_chan #(.W(CW), .BASE(CB)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .tick_slow(tick_slow),
      .tick_fast(tick_fast), .rd_word(ch_rd[i]), .irq(irq[i])
    );
  end

  tmr_free #(.W(FREE_W)) u_free (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .tick_fast(tick_fast), .rd_word(free_rd)
  );

  always_comb begin
    rd_mux = free_rd;
    for (int i = 0; i < N_CH; i++) rd_mux = rd_mux | ch_rd[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/tmr_bank_tb.sv
`timescale 1ns/1ps
module tmr_bank_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, tick_slow = 0, tick_fast = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [2:0] irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  longint t4_exp = 0;
  bit t4_on = 0;

  always #2 clk = ~clk;

  tmr_bank u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tick_slow(tick_slow),
    .tick_fast(tick_fast), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic tick(input bit fast, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); if (fast) tick_fast = 1; else tick_slow = 1;
      @(negedge clk); tick_fast = 0; tick_slow = 0;
      if (fast && t4_on) t4_exp++;
    end
  endtask

  function automatic logic [31:0] base_of(input int ch);
    return (ch == 0) ? 32'h00 : (ch == 1) ? 32'h20 : 32'h80;
  endfunction

  // reference count after n ticks; sets irq flag if any pass through zero
  function automatic logic [31:0] model(input int ch, input logic [31:0] ld,
      input bit per, input int n, output bit fired);
    logic [31:0] m = (ch == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    logic [31:0] c = ld & m;
    fired = 0;
    for (int k = 0; k < n; k++) begin
      if (c == 0) begin c = per ? (ld & m) : m; fired = 1; end
      else c = c - 1;
    end
    return c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit f;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int ch = 0; ch < 3; ch++) begin
      rd(8'(base_of(ch) + 4), v); chk("R1 value", v, 0);
      rd(8'(base_of(ch) + 8), v); chk("R1 ctrl", v, 0);
    end
    rd(8'h60, v); chk("R1 free lo", v, 0);
    rd(8'h64, v); chk("R1 free hi", v, 0);
    chk("R1 irq", 32'(irq), 0);
    // R2 map and readback
    wr(8'h00, 32'hABCD1234); rd(8'h00, v); chk("R2 load t1", v, 32'h1234);
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, v); chk("R2 ctrl bits", v, 32'hC8);
    wr(8'h28, 0);
    rd(8'h0C, v); chk("R2 clear reads 0", v, 0);
    // R3 load while disabled
    wr(8'h00, 5); rd(8'h04, v); chk("R3 copy to count", v, 5);
    // R4 selected strobe only
    wr(8'h08, 32'hC8);
    tick(0, 3); rd(8'h04, v); chk("R4 slow ignored", v, 5);
    tick(1, 2); rd(8'h04, v); chk("R4 fast decrements", v, 3);
    // R5 periodic reload
    tick(1, 3); rd(8'h04, v); chk("R5 at zero", v, 0); chk("R5 no irq yet", 32'(irq[0]), 0);
    tick(1, 1); rd(8'h04, v); chk("R5 reload", v, 5); chk("R5 irq", 32'(irq[0]), 1);
    // R8 clear
    wr(8'h0C, 32'h0); chk("R8 clear", 32'(irq[0]), 0);
    wr(8'h08, 0);
    // R6/R7 one-shot wrap on narrow channel, R9 freeze
    wr(8'h20, 2); wr(8'h28, 32'h80);
    tick(0, 3); rd(8'h24, v); chk("R6 R7 wrap 16", v, 32'hFFFF); chk("R6 irq", 32'(irq[1]), 1);
    wr(8'h28, 0); tick(0, 4);
    rd(8'h24, v); chk("R9 frozen", v, 32'hFFFF); chk("R9 irq kept", 32'(irq[1]), 1);
    wr(8'h2C, 32'h5A); chk("R8 clear t2", 32'(irq[1]), 0);
    // R7 wide wrap
    wr(8'h80, 0); wr(8'h88, 32'h80); tick(0, 1);
    rd(8'h84, v); chk("R7 wrap 32", v, 32'hFFFF_FFFF); chk("R7 irq", 32'(irq[2]), 1);
    wr(8'h88, 0); wr(8'h8C, 1);
    // R10 wide counter
    tick(1, 3); rd(8'h60, v); chk("R10 disabled", v, 0);
    wr(8'h64, 32'h100); t4_on = 1;
    tick(1, 5); rd(8'h60, v); chk("R10 counts", v, 5);
    chk("R10 no irq", 32'(irq), 0);
    // R11 snapshot
    tick(1, 4); rd(8'h64, v); chk("R11 hi", v, 32'h100);
    // random
    for (int it = 0; it < 24; it++) begin
      int ch = $urandom_range(0, 2);
      logic [31:0] ld = $urandom_range(0, 12);
      bit per = $urandom_range(0, 1);
      bit cs = $urandom_range(0, 1);
      int n = $urandom_range(0, 30);
      logic [31:0] b = base_of(ch);
      logic [31:0] exp;
      wr(8'(b + 8), 0); wr(8'(b + 12), 0); wr(8'(b), ld);
      wr(8'(b + 8), (32'(per) << 6) | (32'(cs) << 3) | 32'h80);
      for (int k = 0; k < n; k++) begin
        if ($urandom_range(0, 2) == 0) tick(!cs, 1);
        tick(cs, 1);
      end
      wr(8'(b + 8), 0);
      exp = model(ch, ld, per, n, f);
      rd(8'(b + 4), v); chk(per ? "R5 random count" : "R6 random count", v, exp);
      chk("R4 random irq", 32'(irq[ch]), 32'(f));
    end
    rd(8'h60, v); chk("R10 total", v, t4_exp[31:0]);
    rd(8'h64, v); chk("R11 hi final", v, 32'h100);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule